// File: doc/BRIEF.md
# Data-Processing ALU with Condition Flags

This block carries out the sixteen register-to-register data operations of a 32-bit RISC integer pipeline. It takes the first source register value, the operand already produced by the barrel shifter together with the carry that shifter produced, the current N, Z, C and V condition flags, a four-bit operation code and the flag-update bit. From these it returns the result value and a destination-write enable in the same cycle. The updated condition flags appear on a register output at the next clock edge.

All arithmetic goes through a single adder with three inputs: a source, a modifier and a carry-in. Subtractions feed the inverted operand and a carry-in of one. The carrying variants feed the current C flag as the carry-in. Logical operations set C from the shifter carry and leave V alone. The test and compare codes only affect the flags. A compare code issued with its flag-update bit clear is flagged as an illegal instruction.

Flag vectors are packed as {N, Z, C, V}: bit 3 is N, bit 2 is Z, bit 1 is C and bit 0 is V.

Top module: `dp_alu`

## Requirements
- R1: Opcodes 0 AND, 1 EOR, 12 ORR, 13 MOV, 14 BIC and 15 MVN give Rn&op, Rn^op, Rn|op, op, Rn&~op and ~op on `result` in the same cycle.
- R2: Opcode 2 SUB gives Rn + ~op + 1, and opcode 3 RSB gives op + ~Rn + 1, modulo 2^DATA_W.
- R3: Opcode 4 ADD gives Rn + op, and opcode 5 ADC gives Rn + op + C, where C is bit 1 of `flags_in`.
- R4: Opcode 6 SBC gives Rn + ~op + C, and opcode 7 RSC gives op + ~Rn + C.
- R5: For an arithmetic code (2-7, 10, 11) with `set_flags` high, the flags registered at the next edge are as follows. N is result bit DATA_W-1. Z is set when the result is zero. C is the adder carry-out. V is set when both adder inputs share a sign and the sum's sign differs from it.
- R6: For a logical code (0, 1, 8, 9, 12-15) with `set_flags` high, N and Z come from the result, C takes `shift_carry`, and V keeps bit 0 of `flags_in`.
- R7: Codes 8 TST, 9 TEQ, 10 CMP and 11 CMN hold `wr_en` low and set flags as AND, EOR, SUB and ADD would. Every other code drives `wr_en` high when `exec_en` is high.
- R8: With `set_flags` low, `flags_out` takes the value of `flags_in` at the edge.
- R9: A code from 8 to 11 with `set_flags` low raises `illegal` and writes no destination. The flags are left at `flags_in`.
- R10: While `exec_en` is low, `wr_en` and `illegal` are low and `flags_out` keeps its value.
- R11: During reset `flags_out` is 4'b0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | An operation executes this cycle |
| opcode | input | 4 | Data operation code |
| set_flags | input | 1 | Flag-update bit |
| rn_val | input | DATA_W | First source register value |
| shift_val | input | DATA_W | Shifter operand |
| shift_carry | input | 1 | Carry out of the shifter |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | DATA_W | Operation result |
| wr_en | output | 1 | Destination register write enable |
| illegal | output | 1 | Compare code issued without the flag-update bit |
| flags_out | output | 4 | Registered updated flags {N,Z,C,V} |

## Verification
The assertions assume that `flags_in` is the flag state the pipeline holds, that `exec_en` is low whenever the operands carry no meaning, and that the inputs settle before each rising edge. The stimulus changes inputs only on falling edges. It runs the block at DATA_W=4 and sweeps every opcode, every pair of operands, both C values, both shifter carries and both values of the flag-update bit. N and V on `flags_in` are derived from the operand bits, so every combination reaches the hold paths.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
    OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
    OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
    OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
  } alu_op_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  function automatic logic op_is_compare(input logic [3:0] op);
    return op[3:2] == 2'b10;
  endfunction

  function automatic logic op_is_arith(input logic [3:0] op);
    return (op[3:2] == 2'b01) || (op[3:1] == 3'b001) || (op[3:1] == 3'b101);
  endfunction

endpackage

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] src,
  input  logic [DATA_W-1:0] modi,
  input  logic              cin,
  output logic [DATA_W-1:0] sum,
  output logic              cout,
  output logic              ovf
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;

  always_comb begin
    wide = {1'b0, src} + {1'b0, modi} + {{DATA_W{1'b0}}, cin};
    sum  = wide[MSB:0];
    cout = wide[DATA_W];
    ovf  = ~(src[MSB] ^ modi[MSB]) & (src[MSB] ^ wide[MSB]);
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [3:0]        op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  import alu_pkg::*;

  always_comb begin
    unique case (alu_op_e'(op))
      OP_AND, OP_TST: y = a & b;
      OP_EOR, OP_TEQ: y = a ^ b;
      OP_ORR:         y = a | b;
      OP_MOV:         y = b;
      OP_BIC:         y = a & ~b;
      OP_MVN:         y = ~b;
      default:        y = '0;
    endcase
  end
endmodule

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              upd,
  input  logic              arith,
  input  logic [DATA_W-1:0] res,
  input  logic              add_c,
  input  logic              add_v,
  input  logic              shc,
  input  logic [3:0]        cur,
  output logic [3:0]        q
);
  import alu_pkg::*;

  logic [3:0] nxt;

  always_comb begin
    nxt = cur;
    if (upd) begin
      nxt[FLAG_N] = res[DATA_W-1];
      nxt[FLAG_Z] = (res == '0);
      nxt[FLAG_C] = arith ? add_c : shc;
      nxt[FLAG_V] = arith ? add_v : cur[FLAG_V];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 4'b0000;
    end else if (en) begin
      q <= nxt;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q)); // R10
  AST_LOGIC_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    en && upd && !arith |=> q[FLAG_V] == $past(cur[FLAG_V])); // R6
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_en,
  input  logic [3:0]        opcode,
  input  logic              set_flags,
  input  logic [DATA_W-1:0] rn_val,
  input  logic [DATA_W-1:0] shift_val,
  input  logic              shift_carry,
  input  logic [3:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic              wr_en,
  output logic              illegal,
  output logic [3:0]        flags_out
);
  import alu_pkg::*;

  logic [DATA_W-1:0] add_src, add_mod, add_sum, log_y;
  logic              add_cin, add_cout, add_ovf;
  logic              is_cmp, is_ari, upd;

  assign is_cmp = op_is_compare(opcode);
  assign is_ari = op_is_arith(opcode);

  always_comb begin
    add_src = rn_val;
    add_mod = shift_val;
    add_cin = 1'b0;
    unique case (alu_op_e'(opcode))
      OP_SUB, OP_CMP: begin add_mod = ~shift_val; add_cin = 1'b1; end
      OP_RSB:         begin add_src = shift_val; add_mod = ~rn_val; add_cin = 1'b1; end
      OP_ADC:         add_cin = flags_in[FLAG_C];
      OP_SBC:         begin add_mod = ~shift_val; add_cin = flags_in[FLAG_C]; end
      OP_RSC:         begin add_src = shift_val; add_mod = ~rn_val; add_cin = flags_in[FLAG_C]; end
      default: ;
    endcase
  end

  alu_adder #(.DATA_W(DATA_W)) u_add (
    .src(add_src), .modi(add_mod), .cin(add_cin),
    .sum(add_sum), .cout(add_cout), .ovf(add_ovf)
  );

  alu_logic #(.DATA_W(DATA_W)) u_log (
    .op(opcode), .a(rn_val), .b(shift_val), .y(log_y)
  );

  always_comb begin
    result  = is_ari ? add_sum : log_y;
    wr_en   = exec_en & ~is_cmp;
    illegal = exec_en & is_cmp & ~set_flags;
    upd     = set_flags;
  end

  alu_flags #(.DATA_W(DATA_W)) u_flg (
    .clk(clk), .rst_n(rst_n), .en(exec_en), .upd(upd), .arith(is_ari),
    .res(result), .add_c(add_cout), .add_v(add_ovf), .shc(shift_carry),
    .cur(flags_in), .q(flags_out)
  );

  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && opcode[3:2] == 2'b10 |-> !wr_en); // R7
  AST_ILLEGAL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !wr_en && opcode[3:2] == 2'b10); // R9
  AST_NO_S_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    exec_en && !set_flags |=> flags_out == $past(flags_in)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |-> !wr_en && !illegal); // R10
endmodule

// File: tb/tb_dp_alu.sv
module tb_dp_alu;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk, rst_n, exec_en, set_flags, shift_carry;
  logic [3:0] opcode, flags_in, flags_out;
  logic [W-1:0] rn_val, shift_val, result;
  logic wr_en, illegal;
  int errors, checks;
  bit done;

  dp_alu #(.DATA_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .opcode(opcode),
    .set_flags(set_flags), .rn_val(rn_val), .shift_val(shift_val),
    .shift_carry(shift_carry), .flags_in(flags_in), .result(result),
    .wr_en(wr_en), .illegal(illegal), .flags_out(flags_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s op=%0d rn=%0d b=%0d s=%0b: actual=%0h expected=%0h",
               tag, opcode, rn_val, shift_val, set_flags, act, exp);
    end
  endtask

  function automatic int sx(input int x);
    return (x >= 8) ? x - 16 : x;
  endfunction

  initial begin
    #(CLK_PERIOD * 40000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    errors = 0; checks = 0; done = 0;
    rst_n = 1'b0; exec_en = 1'b0; opcode = 4'd0; set_flags = 1'b0;
    rn_val = '0; shift_val = '0; shift_carry = 1'b0; flags_in = 4'b1111;
    repeat (3) @(posedge clk);
    #1 chk("R11 reset flags", flags_out, 0);
    @(negedge clk) rst_n = 1'b1;

    for (int op = 0; op < 16; op++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          for (int m = 0; m < 8; m++) begin
            int c, shc, s, u, sv, res, ec, ev, arith, cmp, fin, ef;
            string rtag, ftag;
            c = m & 1; shc = (m >> 1) & 1; s = (m >> 2) & 1;
            fin = ((a & 1) << 3) | (((b >> 1) & 1) << 2) | (c << 1) | (((a >> 1) ^ b) & 1);
            arith = 1; u = 0; sv = 0; ec = 0; ev = 0; res = 0;
            cmp = (op >= 8 && op <= 11);
            case (op)
              0, 8:  begin arith = 0; res = a & b; end
              1, 9:  begin arith = 0; res = a ^ b; end
              12:    begin arith = 0; res = a | b; end
              13:    begin arith = 0; res = b; end
              14:    begin arith = 0; res = a & (~b & 15); end
              15:    begin arith = 0; res = ~b & 15; end
              2, 10: begin u = a - b; sv = sx(a) - sx(b); ec = (u >= 0); end
              3:     begin u = b - a; sv = sx(b) - sx(a); ec = (u >= 0); end
              4, 11: begin u = a + b; sv = sx(a) + sx(b); ec = (u > 15); end
              5:     begin u = a + b + c; sv = sx(a) + sx(b) + c; ec = (u > 15); end
              6:     begin u = a - b - (1 - c); sv = sx(a) - sx(b) - (1 - c); ec = (u >= 0); end
              default: begin u = b - a - (1 - c); sv = sx(b) - sx(a) - (1 - c); ec = (u >= 0); end
            endcase
            if (arith) begin
              res = u & 15;
              ev = (sv < -8 || sv > 7);
            end
            if (s) ef = ((res >> 3) << 3) | ((res == 0) << 2) |
                        ((arith ? ec : shc) << 1) | (arith ? ev : (fin & 1));
            else   ef = fin;
            if (cmp) rtag = "R7 compare result";
            else if (!arith) rtag = "R1 logical result";
            else if (op == 2 || op == 3) rtag = "R2 sub/rsb result";
            else if (op == 4 || op == 5) rtag = "R3 add/adc result";
            else rtag = "R4 sbc/rsc result";
            if (!s && cmp) ftag = "R9 illegal keeps flags";
            else if (!s) ftag = "R8 flags held";
            else if (arith) ftag = "R5 arith flags";
            else ftag = "R6 logic flags";

            @(negedge clk);
            exec_en = 1'b1; opcode = op[3:0]; rn_val = a[3:0]; shift_val = b[3:0];
            shift_carry = shc[0]; set_flags = s[0]; flags_in = fin[3:0];
            #1;
            chk(rtag, result, res);
            chk("R7 write enable", wr_en, !cmp);
            chk("R9 illegal", illegal, cmp && !s);
            @(posedge clk); #1;
            chk(ftag, flags_out, ef);
          end

    @(negedge clk);
    exec_en = 1'b1; opcode = 4'd13; set_flags = 1'b1; shift_val = 4'd0;
    shift_carry = 1'b1; flags_in = 4'b0001;
    @(posedge clk); #1 chk("R6 mov zero flags", flags_out, 4'b0111);
    @(negedge clk);
    exec_en = 1'b0; flags_in = 4'b1000; opcode = 4'd10; set_flags = 1'b0;
    #1;
    chk("R10 idle wr_en", wr_en, 0);
    chk("R10 idle illegal", illegal, 0);
    repeat (2) @(posedge clk);
    #1 chk("R10 idle flags hold", flags_out, 4'b0111);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule